// File: doc/BRIEF.md
# Masked Trigger OR and Two-Group Coincidence Unit

This block turns a wide set of discriminator input levels (96 by default) into a small set of trigger outputs (16 by default). Every input is first brought into the 100 MHz clock domain by a two-flop synchroniser. It can then have its polarity flipped and, if selected, its active time lengthened by one clock cycle. Each output except the highest one is the OR of the inputs that its own enable mask selects. The highest output instead carries a coincidence: it is high only when two separately masked input groups have both fired within a four-cycle (40 ns) window.

All masks sit behind a simple word-addressed register port with an 8-bit address, a write strobe, a read strobe and 32-bit data. Read data is registered. The same port returns a live copy of the output word and a fixed word that describes the block's size. Software sets the masks once, and after that the outputs follow the inputs with a fixed latency.

Top module: `trig_or_unit`

## Requirements
- R1: After reset every mask register is zero, `trigOut` is all zero and `busRdata` is zero.
- R2: Output k (k below NUM_OUT-1) is the OR of the inputs whose enable bit is set for it. Its mask occupies words 0x40+4k (inputs 0-31), 0x41+4k (inputs 32-63) and 0x42+4k (inputs 64-95), with input i at bit i mod 32. An input level reaches `trigOut` on the third rising clock edge after it is applied.
- R3: The invert words at 0x24, 0x25 and 0x26 cover inputs 0-31, 32-63 and 64-95. A set bit makes that input active while the pin is low.
- R4: The stretch words at 0x20, 0x21 and 0x22 cover the inputs in the same way. With its bit set, a one-cycle pulse holds the outputs it drives for two cycles. Without the bit, the outputs are held for one cycle.
- R5: Group A is selected by words 0x28-0x2A and group B by words 0x2C-0x2E. Within each group the inputs are ORed. Output NUM_OUT-1 rises when single-cycle pulses from the two groups arrive at most 3 cycles apart. It stays low when they are 4 or more cycles apart, or when only one group fires. The enable mask of that output has no effect.
- R6: A read of word 0x30 returns the current `trigOut` value in its low bits, with the upper bits zero.
- R7: A read of word 0x31 returns NUM_IN/2 in bits 5:0 and NUM_OUT-1 in bits 11:8, with all other bits zero. This is 0x00000F30 for the default size. Writes to 0x30 and 0x31 have no effect.
- R8: A read of an unused word returns zero. These are word 0x43+4k, 0x23, 0x27, 0x2B, 0x2F, anything below 0x20, and anything from 0x32 to 0x3F or from 0x80 up. Writes to such words change nothing that can be read back.
- R9: Every mask word reads back the value last written to it. `busRdata` is updated on the rising edge at which `busRd` is sampled high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigIn | input | NUM_IN | Asynchronous discriminator levels |
| busAddr | input | 8 | Register word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| trigOut | output | NUM_OUT | Trigger outputs, the top bit being the coincidence |

## Verification
The OR function is driven with a table of steady input patterns. Each pattern lights one input in a different 32-bit word, so a misplaced lane or bit would light the wrong output. One input is inverted, which separates the polarity handling from the masking. Patterns with one coincidence group alone, with both groups, and with the input that the top output's own mask selects show that the top output follows only the two-group rule. Directed single-cycle pulses measure the stretch length and the coincidence window edge at 3 and 4 cycles of separation. Register reads check mask readback, the status and size words, and unused words.

// File: rtl/trig_or_pkg.sv
package trig_or_pkg;

  localparam int WORD_W = 32;

  // one write strobe per register family, plus the target selectors
  typedef struct packed {
    logic              wrEnable;
    logic              wrStretch;
    logic              wrInvert;
    logic              wrCoinA;
    logic              wrCoinB;
    logic [3:0]        outSel;
    logic [1:0]        lane;
    logic [WORD_W-1:0] data;
  } cfgWrite_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_ENABLE, RD_STRETCH, RD_INVERT,
    RD_COINA, RD_COINB, RD_STATUS, RD_INFO
  } rdKind_t;

  typedef struct packed {
    rdKind_t    kind;
    logic [3:0] outSel;
    logic [1:0] lane;
  } rdSel_t;

endpackage

// File: rtl/trig_or_coin.sv
module trig_or_coin #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hitA,
  input  logic hitB,
  output logic coinHit
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cntA;
  logic [CNT_W-1:0] cntB;

  // retrigger counters: reload while the group is active, then run down
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntA <= '0;
      cntB <= '0;
    end else begin
      if (hitA)              cntA <= HOLD_VAL;
      else if (cntA != '0)   cntA <= cntA - 1'b1;
      if (hitB)              cntB <= HOLD_VAL;
      else if (cntB != '0)   cntB <= cntB - 1'b1;
    end
  end

  assign coinHit = (cntA != '0) && (cntB != '0);

  a_r5_reload_a: assert property (@(posedge clk) disable iff (!rst_n)
    hitA |=> (cntA == HOLD_VAL));
  a_r5_reload_b: assert property (@(posedge clk) disable iff (!rst_n)
    hitB |=> (cntB == HOLD_VAL));
  a_r5_decay_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitA && cntA != '0) |=> (cntA == $past(cntA) - 1'b1));
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cntA <= HOLD_VAL) && (cntB <= HOLD_VAL));

endmodule

// File: rtl/trig_or_path.sv
module trig_or_path
  import trig_or_pkg::*;
#(
  parameter int NUM_IN   = 96,
  parameter int NUM_OUT  = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IN-1:0]  trigIn,
  input  cfgWrite_t          wr,
  input  rdSel_t             rsel,
  output logic [NUM_OUT-1:0] trigOut,
  output logic [WORD_W-1:0]  readWord
);

  localparam int LANES = (NUM_IN + WORD_W - 1) / WORD_W;
  localparam int PAD_W = LANES * WORD_W;
  localparam logic [WORD_W-1:0] INFO_WORD =
    {20'd0, 4'(NUM_OUT - 1), 2'd0, 6'(NUM_IN / 2)};

  logic [NUM_OUT-1:0][PAD_W-1:0] enMask;
  logic [PAD_W-1:0] stretchEn;
  logic [PAD_W-1:0] invertEn;
  logic [PAD_W-1:0] coinA;
  logic [PAD_W-1:0] coinB;

  logic [NUM_IN-1:0] syncA;
  logic [NUM_IN-1:0] syncB;
  logic [NUM_IN-1:0] polar;
  logic [NUM_IN-1:0] polarD;
  logic [NUM_IN-1:0] active;
  logic [NUM_OUT-1:0] orNext;
  logic hitA;
  logic hitB;
  logic coinHit;
  logic [6:0] wrBase;
  logic [6:0] rdBase;

  assign wrBase = {wr.lane, 5'd0};
  assign rdBase = {rsel.lane, 5'd0};

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enMask    <= '0;
      stretchEn <= '0;
      invertEn  <= '0;
      coinA     <= '0;
      coinB     <= '0;
    end else begin
      if (wr.wrEnable)  enMask[wr.outSel][wrBase +: WORD_W] <= wr.data;
      if (wr.wrStretch) stretchEn[wrBase +: WORD_W] <= wr.data;
      if (wr.wrInvert)  invertEn[wrBase +: WORD_W]  <= wr.data;
      if (wr.wrCoinA)   coinA[wrBase +: WORD_W]     <= wr.data;
      if (wr.wrCoinB)   coinB[wrBase +: WORD_W]     <= wr.data;
    end
  end

  // synchroniser, polarity, one-cycle stretch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA  <= '0;
      syncB  <= '0;
      polarD <= '0;
    end else begin
      syncA  <= trigIn;
      syncB  <= syncA;
      polarD <= polar;
    end
  end

  assign polar  = syncB ^ invertEn[NUM_IN-1:0];
  assign active = polar | (polarD & stretchEn[NUM_IN-1:0]);

  assign hitA = |(active & coinA[NUM_IN-1:0]);
  assign hitB = |(active & coinB[NUM_IN-1:0]);

  trig_or_coin #(.HOLD_CYC(HOLD_CYC)) coin_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hitA    (hitA),
    .hitB    (hitB),
    .coinHit (coinHit)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (k == NUM_OUT - 1) begin : g_coin
      assign orNext[k] = coinHit;
    end else begin : g_or
      assign orNext[k] = |(active & enMask[k][NUM_IN-1:0]);
      a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((active & enMask[k][NUM_IN-1:0]) == '0) |=> !trigOut[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trigOut <= '0;
    else        trigOut <= orNext;
  end

  always_comb begin
    readWord = '0;
    case (rsel.kind)
      RD_ENABLE:  readWord = enMask[rsel.outSel][rdBase +: WORD_W];
      RD_STRETCH: readWord = stretchEn[rdBase +: WORD_W];
      RD_INVERT:  readWord = invertEn[rdBase +: WORD_W];
      RD_COINA:   readWord = coinA[rdBase +: WORD_W];
      RD_COINB:   readWord = coinB[rdBase +: WORD_W];
      RD_STATUS:  readWord = {{(WORD_W-NUM_OUT){1'b0}}, trigOut};
      RD_INFO:    readWord = INFO_WORD;
      default:    readWord = '0;
    endcase
  end

  a_r5_coin_out: assert property (@(posedge clk) disable iff (!rst_n)
    coinHit |=> trigOut[NUM_OUT-1]);
  a_r4_stretch_tail: assert property (@(posedge clk) disable iff (!rst_n)
    ((polarD & stretchEn[NUM_IN-1:0] & enMask[0][NUM_IN-1:0]) != '0) |=> trigOut[0]);

endmodule

// File: rtl/trig_or_ctrl.sv
module trig_or_ctrl
  import trig_or_pkg::*;
#(
  parameter int NUM_IN  = 96,
  parameter int NUM_OUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] readWord,
  output cfgWrite_t         wr,
  output rdSel_t            rsel,
  output logic [WORD_W-1:0] busRdata
);

  localparam int LANES = (NUM_IN + WORD_W - 1) / WORD_W;

  rdKind_t kind;
  logic    laneOk;

  always_comb begin
    laneOk = int'(busAddr[1:0]) < LANES;
    kind   = RD_NONE;
    if (busAddr[7:6] == 2'b01) begin
      if (laneOk && int'(busAddr[5:2]) < NUM_OUT) kind = RD_ENABLE;
    end else if (busAddr[7:4] == 4'h2) begin
      if (laneOk) begin
        case (busAddr[3:2])
          2'd0:    kind = RD_STRETCH;
          2'd1:    kind = RD_INVERT;
          2'd2:    kind = RD_COINA;
          default: kind = RD_COINB;
        endcase
      end
    end else if (busAddr == 8'h30) begin
      kind = RD_STATUS;
    end else if (busAddr == 8'h31) begin
      kind = RD_INFO;
    end
  end

  always_comb begin
    rsel.kind   = kind;
    rsel.outSel = busAddr[5:2];
    rsel.lane   = busAddr[1:0];
    wr.outSel    = busAddr[5:2];
    wr.lane      = busAddr[1:0];
    wr.data      = busWdata;
    wr.wrEnable  = busWr && (kind == RD_ENABLE);
    wr.wrStretch = busWr && (kind == RD_STRETCH);
    wr.wrInvert  = busWr && (kind == RD_INVERT);
    wr.wrCoinA   = busWr && (kind == RD_COINA);
    wr.wrCoinB   = busWr && (kind == RD_COINB);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     busRdata <= '0;
    else if (busRd) busRdata <= readWord;
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr.wrEnable, wr.wrStretch, wr.wrInvert, wr.wrCoinA, wr.wrCoinB}));
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && kind == RD_NONE) |=> (busRdata == '0));
  a_r7_info_word: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && busAddr == 8'h31) |=>
      (busRdata == {20'd0, 4'(NUM_OUT - 1), 2'd0, 6'(NUM_IN / 2)}));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busRd |=> $stable(busRdata));

endmodule

// File: rtl/trig_or_unit.sv
module trig_or_unit
  import trig_or_pkg::*;
#(
  parameter int NUM_IN   = 96,
  parameter int NUM_OUT  = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IN-1:0]  trigIn,
  input  logic [7:0]         busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_OUT-1:0] trigOut
);

  cfgWrite_t         wr;
  rdSel_t            rsel;
  logic [WORD_W-1:0] readWord;

  trig_or_ctrl #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .readWord (readWord),
    .wr       (wr),
    .rsel     (rsel),
    .busRdata (busRdata)
  );

  trig_or_path #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .HOLD_CYC(HOLD_CYC)) path_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigIn   (trigIn),
    .wr       (wr),
    .rsel     (rsel),
    .trigOut  (trigOut),
    .readWord (readWord)
  );

endmodule

// File: tb/trig_or_unit_tb.sv
module trig_or_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] trigIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] trigOut;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  trig_or_unit dut_i (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .trigOut(trigOut)
  );

  // {input pattern, expected trigOut}; input 95 is inverted and feeds output 4
  localparam int NVEC = 10;
  localparam logic [111:0] VECS [NVEC] = '{
    {96'd0,          16'h0010},  // R3: idle low pin on inverted input is active
    {(96'd1 << 0),   16'h0011},  // R2 lane 0; R5 out15 mask (input 0) ignored
    {(96'd1 << 40),  16'h0012},  // R2 lane 1
    {(96'd1 << 70),  16'h0014},  // R2 lane 2
    {(96'd1 << 5),   16'h0018},
    {(96'd1 << 90),  16'h0018},
    {(96'd1 << 95),  16'h0000},  // R3 inverted input driven high
    {(96'd1 << 10),  16'h0010},  // R5 group A alone
    {(96'd1 << 10) | (96'd1 << 20), 16'h8010},  // R5 both groups
    {(96'd1 << 0) | (96'd1 << 40) | (96'd1 << 70) | (96'd1 << 95), 16'h0007}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  // one-cycle pulse on input i, then count cycles with trigOut[bitSel] high
  task automatic pulseCount(input int i, input int bitSel, output int cnt);
    cnt = 0;
    @(negedge clk); trigIn[i] = 1'b1;
    @(negedge clk); trigIn[i] = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (trigOut[bitSel]) cnt++;
    end
  endtask

  task automatic coinTry(input int gap, output bit seen);
    seen = 1'b0;
    @(negedge clk); trigIn[10] = 1'b1;
    @(negedge clk); trigIn[10] = 1'b0;
    for (int c = 1; c < gap; c++) @(negedge clk);
    if (gap == 0) trigIn[10] = 1'b1;
    trigIn[20] = 1'b1;
    @(negedge clk); trigIn[20] = 1'b0; trigIn[10] = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (trigOut[15]) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          cnt;
    bit          seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trigOut == 16'h0, "R1 trigOut after reset", {16'h0, trigOut}, 32'h0);
    check(busRdata == 32'h0, "R1 busRdata after reset", busRdata, 32'h0);
    busRead(8'h40, rd);
    check(rd == 32'h0, "R1 mask after reset", rd, 32'h0);

    busWrite(8'h40, 32'h0000_0001);
    busWrite(8'h45, 32'h0000_0100);
    busWrite(8'h4A, 32'h0000_0040);
    busWrite(8'h4C, 32'h0000_0020);
    busWrite(8'h4E, 32'h0400_0000);
    busWrite(8'h52, 32'h8000_0000);
    busWrite(8'h26, 32'h8000_0000);
    busWrite(8'h28, 32'h0000_0400);
    busWrite(8'h2C, 32'h0010_0000);
    busWrite(8'h7C, 32'h0000_0001);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      trigIn = VECS[v][111:16];
      repeat (8) @(negedge clk);
      check(trigOut == VECS[v][15:0], $sformatf("R2/R3/R5 vector %0d", v),
            {16'h0, trigOut}, {16'h0, VECS[v][15:0]});
    end

    // R2 latency: output follows on the third edge
    @(negedge clk); trigIn = '0;
    repeat (8) @(negedge clk);
    trigIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(trigOut[0] == 1'b0, "R2 not yet after two edges", {31'h0, trigOut[0]}, 32'h0);
    @(negedge clk);
    check(trigOut[0] == 1'b1, "R2 set after three edges", {31'h0, trigOut[0]}, 32'h1);
    trigIn[40] = 1'b1;
    repeat (6) @(negedge clk);

    busRead(8'h30, rd);
    check(rd == 32'h0000_0013, "R6 status word", rd, 32'h13);
    busRead(8'h31, rd);
    check(rd == 32'h0000_0F30, "R7 size word", rd, 32'hF30);
    busWrite(8'h31, 32'hFFFF_FFFF);
    busWrite(8'h30, 32'hFFFF_FFFF);
    busRead(8'h31, rd);
    check(rd == 32'h0000_0F30, "R7 size word after write", rd, 32'hF30);
    busRead(8'h30, rd);
    check(rd == 32'h0000_0013, "R7 status unchanged by write", rd, 32'h13);

    busRead(8'h4A, rd);
    check(rd == 32'h0000_0040, "R9 readback enable", rd, 32'h40);
    busRead(8'h2C, rd);
    check(rd == 32'h0010_0000, "R9 readback group B", rd, 32'h0010_0000);
    busWrite(8'h4B, 32'hDEAD_BEEF);
    busRead(8'h4B, rd);
    check(rd == 32'h0, "R8 unused lane word", rd, 32'h0);
    busWrite(8'h03, 32'hDEAD_BEEF);
    busRead(8'h03, rd);
    check(rd == 32'h0, "R8 low unused word", rd, 32'h0);
    busRead(8'h23, rd);
    check(rd == 32'h0, "R8 unused word 0x23", rd, 32'h0);
    busRead(8'h40, rd);
    check(rd == 32'h0000_0001, "R8 neighbour untouched", rd, 32'h1);
    busRead(8'h30, rd);
    check(rd == 32'h0000_0013, "R8 outputs untouched", rd, 32'h13);
    @(negedge clk);
    busRdata_hold: begin
      logic [31:0] held;
      held = busRdata;
      repeat (3) @(negedge clk);
      check(busRdata == held, "R9 read data holds", busRdata, held);
    end

    @(negedge clk); trigIn = '0;
    repeat (8) @(negedge clk);
    pulseCount(0, 0, cnt);
    check(cnt == 1, "R4 unstretched pulse", cnt, 1);
    busWrite(8'h20, 32'h0000_0001);
    repeat (4) @(negedge clk);
    pulseCount(0, 0, cnt);
    check(cnt == 2, "R4 stretched pulse", cnt, 2);
    busRead(8'h20, rd);
    check(rd == 32'h1, "R9 readback stretch", rd, 32'h1);

    coinTry(0, seen);
    check(seen, "R5 same-cycle groups", {31'h0, seen}, 32'h1);
    coinTry(3, seen);
    check(seen, "R5 gap 3 inside window", {31'h0, seen}, 32'h1);
    coinTry(4, seen);
    check(!seen, "R5 gap 4 outside window", {31'h0, seen}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule